// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block sits between instruction decode and issue. When decode presents an instruction that names a tagged vector operand, it pulses a start input. The sequencer then holds the program counter and walks the element index, one step per clock, from its current offset up to the last element of the vector length (VL). At each step a predicate mask bit picks one of three outcomes for the element: it is issued to the datapath, it is skipped, or zero is written to its destination position. When the loop ends, a one-cycle strobe lets the program counter move on.

The element offsets are architectural state. They survive an exception on an element, so a restarted instruction picks up where the trapped one stopped. A write of VL clears them. In fail-on-first mode, the first element whose result is zero ends the loop early and shrinks VL to that element's index. With zeroing enabled, a masked-off element counts as such a zero result. Each element result is reported by the datapath in the same cycle as its issue strobe. Sub-vector looping and the datapath itself are outside this block.

Top module: `elem_loop_sequencer`

## Requirements
- R1: After reset, VL reads 1, both offsets read 0, and no issue, zero-write or PC-advance strobe is asserted.
- R2: A VL write stores the value clamped to the range 1 to MAX_VL, with 0 stored as 1, and returns both offsets to 0 on the next cycle.
- R3: After a start pulse, the loop begins in the following cycle at the current offset, not at 0. It handles one element per cycle. While issueReady is low, an element that needs the datapath (issued or zero-written) is held, with no strobe and no change to the offsets.
- R4: The effective mask bit of element i is predMask[i] XOR predInvert. When that bit is 1, issueValid is asserted with elemIdx = i.
- R5: Without zeroing, a masked-off element produces no strobe, takes one cycle and advances the offset.
- R6: With zeroing, a masked-off element asserts zeroWrValid with elemIdx set to its index, and never asserts issueValid.
- R7: An exception on an issued element (resExc high with issueValid) ends the loop without a PC-advance strobe and leaves both offsets at that element. The next start issues that element first.
- R8: When the element at index VL-1 finishes without exception, pcAdvance pulses for exactly one cycle and both offsets return to 0.
- R9: In fail-on-first mode, a zero result on an issued element i sets VL to i, asserts pcAdvance and clears the offsets. Without zeroing, masked-off elements never end the loop.
- R10: In fail-on-first mode with zeroing, a masked-off element i is zero-written, then VL becomes i and the loop ends with pcAdvance.
- R11: With VL equal to 1, exactly one element is issued, at index 0. With VL equal to 0 (left by fail-on-first at element 0), the loop asserts pcAdvance in its first cycle and issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vlWrEn | input | 1 | Write strobe for VL |
| vlWrData | input | VL_W | Requested VL value |
| instStart | input | 1 | Pulse: a tagged instruction begins |
| predMask | input | MAX_VL | Predicate mask, bit i for element i |
| predInvert | input | 1 | Invert mask bits before use |
| predZeroing | input | 1 | Zero masked-off elements instead of skipping them |
| failFirst | input | 1 | Enable fail-on-first termination |
| issueReady | input | 1 | Datapath can accept an element this cycle |
| resZero | input | 1 | The issued element's result is zero (same cycle) |
| resExc | input | 1 | The issued element raised an exception (same cycle) |
| issueValid | output | 1 | Element issue strobe |
| zeroWrValid | output | 1 | Zero-write strobe |
| elemIdx | output | IDX_W | Index of the element being issued or zeroed |
| pcAdvance | output | 1 | One-cycle strobe: the instruction is finished |
| vlOut | output | VL_W | Current VL, including any fail-on-first truncation |
| srcOffs | output | IDX_W | Current source element offset |
| dstOffs | output | IDX_W | Current destination element offset |

## Verification
A corrupted offset shows at the ports in the first loop cycle after the next start: elemIdx reports the wrong element, or a masked element is handled as active. A skipped element shows up as a missing index in the issued set. A lost clear after completion shows up as a non-zero offset straight after pcAdvance, and as a shifted first index on the next instruction. A wrong VL after fail-on-first shows on vlOut one cycle after the terminating element, and on the length of the next loop. Each table run checks the issued set, the zeroed set, the loop length, the final VL and both offsets, so such faults show within one instruction.

// File: rtl/elem_seq_pkg.sv
package elem_seq_pkg;

  // Control-to-datapath strobes, at most one acts per cycle by priority
  typedef struct packed {
    logic adv;    // step the element offsets by one
    logic clr;    // return the element offsets to zero
    logic trunc;  // set VL to the current index and clear the offsets
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

endpackage

// File: rtl/elem_seq_ctrl.sv
module elem_seq_ctrl
  import elem_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       instStart,
  input  logic       elemOn,
  input  logic       isLast,
  input  logic       vlZero,
  input  logic       zeroing,
  input  logic       failFirst,
  input  logic       issueReady,
  input  logic       resZero,
  input  logic       resExc,
  output seqStrobe_t strobes,
  output logic       issueValid,
  output logic       zeroWrValid,
  output logic       pcAdvance
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobes     = '0;
    issueValid  = 1'b0;
    zeroWrValid = 1'b0;
    pcAdvance   = 1'b0;
    if (state == SEQ_IDLE) begin
      if (instStart) stateNext = SEQ_RUN;
    end else if (vlZero) begin
      strobes.clr = 1'b1;
      pcAdvance   = 1'b1;
      stateNext   = SEQ_IDLE;
    end else if (elemOn) begin
      if (issueReady) begin
        issueValid = 1'b1;
        if (resExc) begin
          stateNext = SEQ_IDLE;
        end else if (failFirst && resZero) begin
          strobes.trunc = 1'b1;
          pcAdvance     = 1'b1;
          stateNext     = SEQ_IDLE;
        end else if (isLast) begin
          strobes.clr = 1'b1;
          pcAdvance   = 1'b1;
          stateNext   = SEQ_IDLE;
        end else begin
          strobes.adv = 1'b1;
        end
      end
    end else if (zeroing) begin
      if (issueReady) begin
        zeroWrValid = 1'b1;
        if (failFirst) begin
          strobes.trunc = 1'b1;
          pcAdvance     = 1'b1;
          stateNext     = SEQ_IDLE;
        end else if (isLast) begin
          strobes.clr = 1'b1;
          pcAdvance   = 1'b1;
          stateNext   = SEQ_IDLE;
        end else begin
          strobes.adv = 1'b1;
        end
      end
    end else if (isLast) begin
      strobes.clr = 1'b1;
      pcAdvance   = 1'b1;
      stateNext   = SEQ_IDLE;
    end else begin
      strobes.adv = 1'b1;
    end
  end

  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issueValid, zeroWrValid}));

  // R8
  pc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcAdvance |=> !pcAdvance);

endmodule

// File: rtl/elem_seq_dp.sv
module elem_seq_dp
  import elem_seq_pkg::*;
#(
  parameter int MAX_VL = 32,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vlWrEn,
  input  logic [VL_W-1:0]   vlWrData,
  input  seqStrobe_t        strobes,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              predInvert,
  output logic              elemOn,
  output logic              isLast,
  output logic              vlZero,
  output logic [VL_W-1:0]   vlOut,
  output logic [IDX_W-1:0]  srcOffs,
  output logic [IDX_W-1:0]  dstOffs
);

  localparam logic [VL_W-1:0] VL_MAX = VL_W'(MAX_VL);
  localparam logic [VL_W-1:0] VL_ONE = VL_W'(1);

  logic [VL_W-1:0]  vlReg, vlClamped;
  logic [IDX_W-1:0] srcReg, dstReg;

  always_comb begin
    if (vlWrData == '0)         vlClamped = VL_ONE;
    else if (vlWrData > VL_MAX) vlClamped = VL_MAX;
    else                        vlClamped = vlWrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlReg  <= VL_ONE;
      srcReg <= '0;
      dstReg <= '0;
    end else if (vlWrEn) begin
      vlReg  <= vlClamped;
      srcReg <= '0;
      dstReg <= '0;
    end else if (strobes.trunc) begin
      vlReg  <= {1'b0, dstReg};
      srcReg <= '0;
      dstReg <= '0;
    end else if (strobes.clr) begin
      srcReg <= '0;
      dstReg <= '0;
    end else if (strobes.adv) begin
      srcReg <= srcReg + IDX_W'(1);
      dstReg <= dstReg + IDX_W'(1);
    end
  end

  assign elemOn  = predMask[dstReg] ^ predInvert;
  assign isLast  = ({1'b0, dstReg} == (vlReg - VL_ONE));
  assign vlZero  = (vlReg == '0);
  assign vlOut   = vlReg;
  assign srcOffs = srcReg;
  assign dstOffs = dstReg;

  // R2
  vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlReg <= VL_MAX);

  // R2
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vlWrEn |=> (srcReg == '0 && dstReg == '0 && vlReg != '0));

  // R3
  offs_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vlReg != '0) |-> ({1'b0, dstReg} < vlReg && {1'b0, srcReg} < vlReg));

endmodule

// File: rtl/elem_loop_sequencer.sv
module elem_loop_sequencer
  import elem_seq_pkg::*;
#(
  parameter int MAX_VL = 32,
  localparam int IDX_W = $clog2(MAX_VL),
  localparam int VL_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vlWrEn,
  input  logic [VL_W-1:0]   vlWrData,
  input  logic              instStart,
  input  logic [MAX_VL-1:0] predMask,
  input  logic              predInvert,
  input  logic              predZeroing,
  input  logic              failFirst,
  input  logic              issueReady,
  input  logic              resZero,
  input  logic              resExc,
  output logic              issueValid,
  output logic              zeroWrValid,
  output logic [IDX_W-1:0]  elemIdx,
  output logic              pcAdvance,
  output logic [VL_W-1:0]   vlOut,
  output logic [IDX_W-1:0]  srcOffs,
  output logic [IDX_W-1:0]  dstOffs
);

  seqStrobe_t strobes;
  logic       elemOn, isLast, vlZero;

  elem_seq_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .instStart   (instStart),
    .elemOn      (elemOn),
    .isLast      (isLast),
    .vlZero      (vlZero),
    .zeroing     (predZeroing),
    .failFirst   (failFirst),
    .issueReady  (issueReady),
    .resZero     (resZero),
    .resExc      (resExc),
    .strobes     (strobes),
    .issueValid  (issueValid),
    .zeroWrValid (zeroWrValid),
    .pcAdvance   (pcAdvance)
  );

  elem_seq_dp #(.MAX_VL(MAX_VL)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .vlWrEn     (vlWrEn),
    .vlWrData   (vlWrData),
    .strobes    (strobes),
    .predMask   (predMask),
    .predInvert (predInvert),
    .elemOn     (elemOn),
    .isLast     (isLast),
    .vlZero     (vlZero),
    .vlOut      (vlOut),
    .srcOffs    (srcOffs),
    .dstOffs    (dstOffs)
  );

  assign elemIdx = dstOffs;

  // R7
  exc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issueValid && resExc && !vlWrEn) |=> (dstOffs == $past(dstOffs) && !pcAdvance));

endmodule

// File: tb/test_elem_loop_sequencer.sv
module test_elem_loop_sequencer;

  localparam int MAX_VL = 32;
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = IDX_W + 1;

  typedef struct packed {
    logic [5:0] vl;
    logic [7:0] mask;
    logic       inv;
    logic       zer;
    logic       ff;
    logic [3:0] zeroAt;    // 15 = no zero result
    logic [7:0] expIssue;
    logic [7:0] expZero;
    logic [5:0] expVl;
    logic [3:0] expCycles;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{6'd4, 8'h0F, 1'b0, 1'b0, 1'b0, 4'd15, 8'h0F, 8'h00, 6'd4, 4'd4}, // R4 all on
    '{6'd4, 8'h05, 1'b0, 1'b0, 1'b0, 4'd15, 8'h05, 8'h00, 6'd4, 4'd4}, // R5 skip
    '{6'd4, 8'h05, 1'b0, 1'b1, 1'b0, 4'd15, 8'h05, 8'h0A, 6'd4, 4'd4}, // R6 zeroing
    '{6'd4, 8'h05, 1'b1, 1'b0, 1'b0, 4'd15, 8'h0A, 8'h00, 6'd4, 4'd4}, // R4 invert
    '{6'd6, 8'h3F, 1'b0, 1'b0, 1'b1, 4'd3,  8'h0F, 8'h00, 6'd3, 4'd4}, // R9 zero at 3
    '{6'd6, 8'h3B, 1'b0, 1'b1, 1'b1, 4'd15, 8'h03, 8'h04, 6'd2, 4'd3}, // R10
    '{6'd6, 8'h3B, 1'b0, 1'b0, 1'b1, 4'd15, 8'h3B, 8'h00, 6'd6, 4'd6}, // R9 masked no stop
    '{6'd1, 8'h01, 1'b0, 1'b0, 1'b0, 4'd15, 8'h01, 8'h00, 6'd1, 4'd1}, // R11 VL=1
    '{6'd8, 8'h00, 1'b0, 1'b0, 1'b0, 4'd15, 8'h00, 8'h00, 6'd8, 4'd8}  // R5 all skipped
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              vlWrEn = 1'b0;
  logic [VL_W-1:0]   vlWrData = '0;
  logic              instStart = 1'b0;
  logic [MAX_VL-1:0] predMask = '0;
  logic              predInvert = 1'b0;
  logic              predZeroing = 1'b0;
  logic              failFirst = 1'b0;
  logic              issueReady = 1'b1;
  logic              resZero, resExc;
  logic              issueValid, zeroWrValid, pcAdvance;
  logic [IDX_W-1:0]  elemIdx, srcOffs, dstOffs;
  logic [VL_W-1:0]   vlOut;

  int zeroAt = 99;
  int excAt  = 99;
  int checks = 0;
  int errors = 0;
  int cycCount = 0;

  always #4 clk = ~clk;

  assign resZero = issueValid && (int'(elemIdx) == zeroAt);
  assign resExc  = issueValid && (int'(elemIdx) == excAt);

  elem_loop_sequencer #(.MAX_VL(MAX_VL)) i_elem_loop_sequencer (
    .clk(clk), .rst_n(rst_n), .vlWrEn(vlWrEn), .vlWrData(vlWrData),
    .instStart(instStart), .predMask(predMask), .predInvert(predInvert),
    .predZeroing(predZeroing), .failFirst(failFirst), .issueReady(issueReady),
    .resZero(resZero), .resExc(resExc), .issueValid(issueValid),
    .zeroWrValid(zeroWrValid), .elemIdx(elemIdx), .pcAdvance(pcAdvance),
    .vlOut(vlOut), .srcOffs(srcOffs), .dstOffs(dstOffs)
  );

  always @(posedge clk) begin
    cycCount <= cycCount + 1;
    if (cycCount > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycCount);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic writeVl(input int v);
    @(negedge clk);
    vlWrEn   = 1'b1;
    vlWrData = VL_W'(v);
    @(negedge clk);
    vlWrEn   = 1'b0;
  endtask

  task automatic runInst(input int maxCyc, output logic [31:0] issued,
                         output logic [31:0] zeroed, output int cycles,
                         output bit advSeen);
    issued = '0; zeroed = '0; cycles = 0; advSeen = 1'b0;
    @(negedge clk);
    instStart = 1'b1;
    @(negedge clk);
    instStart = 1'b0;
    while (!advSeen && cycles < maxCyc) begin
      if (cycles > 0) @(negedge clk);
      cycles++;
      if (issueValid)  issued[elemIdx] = 1'b1;
      if (zeroWrValid) zeroed[elemIdx] = 1'b1;
      if (pcAdvance)   advSeen = 1'b1;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] iss, zer;
    int cyc;
    bit adv;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(vlOut == 6'd1, "R1", "reset VL", vlOut, 1);
    check(srcOffs == '0 && dstOffs == '0, "R1", "reset offsets", dstOffs, 0);
    check(!issueValid && !zeroWrValid && !pcAdvance, "R1", "reset strobes",
          {issueValid, zeroWrValid, pcAdvance}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!issueValid && !zeroWrValid && !pcAdvance, "R1", "idle strobes",
          {issueValid, zeroWrValid, pcAdvance}, 0);

    // R2: clamping
    writeVl(0);
    check(vlOut == 6'd1, "R2", "VL write 0 clamps", vlOut, 1);
    writeVl(40);
    check(vlOut == 6'd32, "R2", "VL write 40 clamps", vlOut, 32);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      writeVl(int'(VEC[k].vl));
      predMask    = {24'h0, VEC[k].mask};
      predInvert  = VEC[k].inv;
      predZeroing = VEC[k].zer;
      failFirst   = VEC[k].ff;
      zeroAt      = (VEC[k].zeroAt == 4'd15) ? 99 : int'(VEC[k].zeroAt);
      runInst(12, iss, zer, cyc, adv);
      // R8: pulse gone one cycle later (sampled inside runInst's last negedge)
      check(!pcAdvance, "R8", $sformatf("vec%0d pulse width", k), pcAdvance, 0);
      check(adv, "R8", $sformatf("vec%0d pc advance", k), adv, 1);
      check(iss[7:0] == VEC[k].expIssue, "R4", $sformatf("vec%0d issued set", k),
            iss, VEC[k].expIssue);
      check(zer[7:0] == VEC[k].expZero, "R6", $sformatf("vec%0d zeroed set", k),
            zer, VEC[k].expZero);
      check(cyc == int'(VEC[k].expCycles), "R3", $sformatf("vec%0d loop cycles", k),
            cyc, VEC[k].expCycles);
      check(vlOut == VEC[k].expVl, "R9", $sformatf("vec%0d final VL", k),
            vlOut, VEC[k].expVl);
      check(srcOffs == '0 && dstOffs == '0, "R8", $sformatf("vec%0d offsets cleared", k),
            {srcOffs, dstOffs}, 0);
    end
    zeroAt = 99; predInvert = 1'b0; predZeroing = 1'b0; failFirst = 1'b0;

    // R7: exception at element 2 holds offsets, resume from there
    writeVl(5);
    predMask = 32'h1F;
    excAt = 2;
    runInst(6, iss, zer, cyc, adv);
    check(!adv, "R7", "no pc advance on exception", adv, 0);
    check(iss[7:0] == 8'h07, "R7", "issued up to faulting element", iss, 8'h07);
    check(srcOffs == 5'd2 && dstOffs == 5'd2, "R7", "offsets held", dstOffs, 2);
    excAt = 99;
    runInst(8, iss, zer, cyc, adv);
    check(iss[7:0] == 8'h1C, "R3", "resume from current offset", iss, 8'h1C);
    check(adv && cyc == 3, "R7", "resumed loop length", cyc, 3);

    // R2: VL write clears non-zero offsets
    excAt = 1;
    runInst(6, iss, zer, cyc, adv);
    check(dstOffs == 5'd1, "R7", "offset at faulting element", dstOffs, 1);
    excAt = 99;
    writeVl(3);
    check(srcOffs == '0 && dstOffs == '0, "R2", "VL write clears offsets", dstOffs, 0);
    check(vlOut == 6'd3, "R2", "VL written", vlOut, 3);

    // R3: issueReady low stalls
    issueReady = 1'b0;
    @(negedge clk);
    instStart = 1'b1;
    @(negedge clk);
    instStart = 1'b0;
    check(!issueValid && !pcAdvance, "R3", "stall no issue", issueValid, 0);
    @(negedge clk);
    check(!issueValid && dstOffs == '0, "R3", "stall holds offset", dstOffs, 0);
    issueReady = 1'b1;
    #1;
    check(issueValid && elemIdx == '0, "R3", "issue on ready", elemIdx, 0);
    @(negedge clk);
    check(issueValid && elemIdx == 5'd1, "R3", "next element", elemIdx, 1);
    @(negedge clk);
    check(issueValid && elemIdx == 5'd2 && pcAdvance, "R8", "last element advances",
          elemIdx, 2);
    @(negedge clk);

    // R11: fail-on-first at element 0 leaves VL 0, then empty loop
    writeVl(4);
    predMask = 32'hF;
    failFirst = 1'b1;
    zeroAt = 0;
    runInst(8, iss, zer, cyc, adv);
    check(vlOut == '0, "R9", "VL truncated to 0", vlOut, 0);
    check(iss[7:0] == 8'h01 && cyc == 1, "R9", "stopped at element 0", iss, 1);
    failFirst = 1'b0;
    zeroAt = 99;
    runInst(8, iss, zer, cyc, adv);
    check(adv && cyc == 1, "R11", "VL 0 advances at once", cyc, 1);
    check(iss == '0 && zer == '0, "R11", "VL 0 issues nothing", iss, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule